// File: doc/BRIEF.md
# Tag reply turnaround checker

This block watches two digital lines in a UHF RFID test setup. One is the demodulated reader envelope and the other is the tag backscatter modulation. It measures how long the tag waits after the end of a reader command before it starts to reply. It then sorts that delay into one of three results: inside the allowed window, too early, or too late or missing. A test setup can use the block to prove that a tag model replies in time. It can also confirm that replies placed early on purpose are caught.

The window is not a fixed timeout. It is rebuilt from three run-time inputs:
- the measured reader calibration interval,
- the link period,
- a tolerance code.

The nominal turnaround is the larger of the calibration interval and ten link periods. A tolerance fraction widens or narrows that nominal value, and a fixed slack of 2 µs (80 ticks of 25 ns) is then taken off the lower bound and added to the upper bound. All times are counted in clock cycles of the 40 MHz tick clock.

The end of a command is found as follows. After a rising edge of the envelope, the envelope must stay high for more than a programmable quiet time. The turnaround is counted from that last rising edge.

Top module: `t1_turnaround_checker`

## Requirements
- R1: While reset is held and in the first cycle after it, `t1_ticks_o` is 0 and all three result strobes are low.
- R2: A command counts as finished only when the envelope has stayed high for more than `quiet_i` cycles since its latest rising edge. Every new envelope rising edge before that point restarts the timing.
- R3: The measured turnaround is the number of clock edges from the edge that first samples the envelope high (the command's last rising edge) to the edge that first samples the tag line high. The result strobe and `t1_ticks_o` are updated on that second edge.
- R4: The window is built from a nominal value N = max(`rtcal_i`, 10·`link_period_i`).
  - The tolerance code selects f/256 with f = 10, 26, 38, 56 for codes 0, 1, 2, 3.
  - The lower bound is floor(N·(256−f)/256) − 80, clamped at 0.
  - The upper bound is floor(N·(256+f)/256) + 80, clamped at 2^CNT_W − 2.
- R5: A tag rising edge after the command has ended, with lower ≤ T1 ≤ upper, raises `t1_valid_o` and reports T1.
- R6: `t1_early_o` is raised in two cases. The first is a tag rising edge after the command has ended with T1 < lower. The second is a tag rising edge while the envelope is high after a command's rising edge, before the end of the command is recognised.
- R7: A tag rising edge with T1 > upper raises `t1_late_o`. If no tag edge comes, `t1_late_o` is raised on the edge where the count first exceeds the upper bound, and T1 is reported as upper + 1.
- R8: At most one result strobe is high in any cycle. Each strobe lasts one cycle per measurement, after which the block returns to idle. `t1_ticks_o` holds its value until the next result.
- R9: Tag rising edges are ignored in two cases: while no command is in progress, and while the envelope is low during a command. They raise no strobe and do not change `t1_ticks_o`.
- R10: The calibration, link period and tolerance inputs are registered. The window they define applies from the cycle after they are applied, and they must stay steady during a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdr_env_i | input | 1 | Reader envelope level, synchronous to clk |
| tag_mod_i | input | 1 | Tag modulation level, synchronous to clk |
| rtcal_i | input | CNT_W | Reader calibration interval in ticks |
| link_period_i | input | LP_W | Link period in ticks |
| tol_code_i | input | 2 | Tolerance code (R4) |
| quiet_i | input | CNT_W | Envelope high time that ends a command, in ticks |
| t1_ticks_o | output | CNT_W | Last measured turnaround in ticks |
| t1_valid_o | output | 1 | One-cycle strobe: turnaround inside window |
| t1_early_o | output | 1 | One-cycle strobe: turnaround below window |
| t1_late_o | output | 1 | One-cycle strobe: turnaround above window or no reply |

## Verification
The assertions that compare the reported turnaround with the window take two things for granted: the timing configuration and `quiet_i` do not change during a measurement, and `quiet_i` is below the upper bound. The stimulus changes the configuration only while the block is idle, and only many cycles before the next command. Both lines are assumed to be already synchronous to the clock. The bench therefore drives them only on falling clock edges. All command pulses are shorter than the quiet time, so a command ends only on its final high stretch.

// File: rtl/t1chk_pkg.sv
package t1chk_pkg;

  localparam int unsigned FRAC_BITS   = 8;
  localparam int unsigned EDGE_SLACK  = 80;
  localparam int unsigned LINK_CYCLES = 10;
  localparam int unsigned WIDE        = 40;

  typedef logic [WIDE-1:0] wide_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CMD   = 2'd1,
    PH_REPLY = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    RES_NONE  = 2'd0,
    RES_VALID = 2'd1,
    RES_EARLY = 2'd2,
    RES_LATE  = 2'd3
  } verdict_e;

  // tolerance fraction in 1/256 units
  function automatic wide_t tol_frac(input logic [1:0] code);
    case (code)
      2'd0:    return wide_t'(10);
      2'd1:    return wide_t'(26);
      2'd2:    return wide_t'(38);
      default: return wide_t'(56);
    endcase
  endfunction

  function automatic wide_t nominal(input wide_t rtcal, input wide_t period);
    wide_t ten;
    ten = period * wide_t'(LINK_CYCLES);
    return (rtcal > ten) ? rtcal : ten;
  endfunction

  function automatic wide_t scaled(input wide_t base, input wide_t num);
    return (base * num) >> FRAC_BITS;
  endfunction

  function automatic wide_t lower_bound(input wide_t base, input logic [1:0] code);
    wide_t s;
    s = scaled(base, (wide_t'(1) << FRAC_BITS) - tol_frac(code));
    return (s > wide_t'(EDGE_SLACK)) ? s - wide_t'(EDGE_SLACK) : wide_t'(0);
  endfunction

  function automatic wide_t upper_bound(input wide_t base, input logic [1:0] code,
                                        input wide_t cap);
    wide_t s;
    s = scaled(base, (wide_t'(1) << FRAC_BITS) + tol_frac(code)) + wide_t'(EDGE_SLACK);
    return (s > cap) ? cap : s;
  endfunction

  function automatic verdict_e classify(input wide_t t, input wide_t lo, input wide_t hi);
    if (t < lo)      return RES_EARLY;
    else if (t > hi) return RES_LATE;
    else             return RES_VALID;
  endfunction

endpackage

// File: rtl/t1chk_edges.sv
module t1chk_edges #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  for (genvar g = 0; g < N; g++) begin : g_line
    logic prev_q;

    // lines held high through reset do not count as a rise
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl_i[g];
    end

    assign rise_o[g] = lvl_i[g] & ~prev_q;

    // R3: a rising edge is one sampled transition, never two in a row
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[g] |=> !rise_o[g]);
  end

endmodule

// File: rtl/t1chk_window.sv
module t1chk_window
  import t1chk_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LP_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rtcal_i,
  input  logic [LP_W-1:0]  period_i,
  input  logic [1:0]       tol_i,
  output logic [CNT_W-1:0] lo_o,
  output logic [CNT_W-1:0] hi_o
);

  localparam wide_t CAP = wide_t'((64'd1 << CNT_W) - 64'd2);

  wide_t base_w, lo_w, hi_w;

  always_comb begin
    base_w = nominal(wide_t'(rtcal_i), wide_t'(period_i));
    lo_w   = lower_bound(base_w, tol_i);
    hi_w   = upper_bound(base_w, tol_i, CAP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_o <= '0;
      hi_o <= '0;
    end else begin
      lo_o <= CNT_W'(lo_w);
      hi_o <= CNT_W'(hi_w);
    end
  end

  // R4: the lower edge of the window never passes the upper edge
  p_window_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lo_o <= hi_o);

endmodule

// File: rtl/t1chk_ctrl.sv
module t1chk_ctrl
  import t1chk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdr_lvl_i,
  input  logic             rdr_rise_i,
  input  logic             tag_rise_i,
  input  logic [CNT_W-1:0] quiet_i,
  input  logic [CNT_W-1:0] lo_i,
  input  logic [CNT_W-1:0] hi_i,
  output logic [CNT_W-1:0] t1_o,
  output logic             valid_o,
  output logic             early_o,
  output logic             late_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  verdict_e         verdict;

  // named internal events
  logic cmd_done, reply_timeout, in_reply, any_result, early_in_cmd;

  assign cnt_inc       = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign cmd_done      = rdr_lvl_i && (cnt_q > quiet_i);
  assign reply_timeout = cnt_q > hi_i;
  assign early_in_cmd  = tag_rise_i && rdr_lvl_i;
  assign in_reply      = (phase_q == PH_REPLY);
  assign any_result    = valid_o | early_o | late_o;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    verdict = RES_NONE;
    case (phase_q)
      PH_IDLE: begin
        if (rdr_rise_i) begin
          phase_d = PH_CMD;
          cnt_d   = CNT_W'(1);
        end
      end
      PH_CMD: begin
        cnt_d = cnt_inc;
        if (early_in_cmd) begin
          verdict = RES_EARLY;
          phase_d = PH_IDLE;
        end else if (rdr_rise_i) begin
          cnt_d = CNT_W'(1);
        end else if (cmd_done) begin
          phase_d = PH_REPLY;
        end
      end
      PH_REPLY: begin
        cnt_d = cnt_inc;
        if (tag_rise_i) begin
          verdict = classify(wide_t'(cnt_q), wide_t'(lo_i), wide_t'(hi_i));
          phase_d = PH_IDLE;
        end else if (reply_timeout) begin
          verdict = RES_LATE;
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      t1_o    <= '0;
      valid_o <= 1'b0;
      early_o <= 1'b0;
      late_o  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      valid_o <= (verdict == RES_VALID);
      early_o <= (verdict == RES_EARLY);
      late_o  <= (verdict == RES_LATE);
      if (verdict != RES_NONE) t1_o <= cnt_q;
    end
  end

  // R8: strobes exclusive
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({valid_o, early_o, late_o}));

  // R8: one cycle per measurement
  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_result |=> !any_result);

  // R8: reported turnaround is held between results
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_result |-> $stable(t1_o));

  // R8: a result always leaves the block idle
  p_idle_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_result |-> phase_q == PH_IDLE);

  // R5: an accepted turnaround lies inside the window
  p_valid_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (t1_o >= lo_i) && (t1_o <= hi_i));

  // R7: a late result always lies beyond the window
  p_late_beyond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    late_o |-> t1_o > hi_i);

  // R2: the reply phase only runs after the quiet time has passed
  p_reply_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_reply |-> cnt_q > quiet_i);

endmodule

// File: rtl/t1_turnaround_checker.sv
module t1_turnaround_checker #(
  parameter int CNT_W = 16,
  parameter int LP_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rdr_env_i,
  input  logic             tag_mod_i,
  input  logic [CNT_W-1:0] rtcal_i,
  input  logic [LP_W-1:0]  link_period_i,
  input  logic [1:0]       tol_code_i,
  input  logic [CNT_W-1:0] quiet_i,
  output logic [CNT_W-1:0] t1_ticks_o,
  output logic             t1_valid_o,
  output logic             t1_early_o,
  output logic             t1_late_o
);

  localparam int LINES = 2;
  localparam int RDR   = 0;
  localparam int TAG   = 1;

  logic [LINES-1:0] lvl, rise;
  logic [CNT_W-1:0] win_lo, win_hi;

  assign lvl[RDR] = rdr_env_i;
  assign lvl[TAG] = tag_mod_i;

  t1chk_edges #(.N(LINES)) u_edges (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  t1chk_window #(.CNT_W(CNT_W), .LP_W(LP_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .rtcal_i  (rtcal_i),
    .period_i (link_period_i),
    .tol_i    (tol_code_i),
    .lo_o     (win_lo),
    .hi_o     (win_hi)
  );

  t1chk_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdr_lvl_i  (rdr_env_i),
    .rdr_rise_i (rise[RDR]),
    .tag_rise_i (rise[TAG]),
    .quiet_i    (quiet_i),
    .lo_i       (win_lo),
    .hi_i       (win_hi),
    .t1_o       (t1_ticks_o),
    .valid_o    (t1_valid_o),
    .early_o    (t1_early_o),
    .late_o     (t1_late_o)
  );

endmodule

// File: tb/t1_turnaround_checker_test.sv
`timescale 1ns/1ps
module t1_turnaround_checker_test;

  localparam int CW = 16;
  localparam int LW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rdr = 1'b1;
  logic          tag = 1'b0;
  logic [CW-1:0] rtcal = 16'd250;
  logic [LW-1:0] per = 12'd62;
  logic [1:0]    code = 2'd3;
  logic [CW-1:0] quiet = 16'd100;
  logic [CW-1:0] t1;
  logic          v, e, l;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  t1_turnaround_checker #(.CNT_W(CW), .LP_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .rdr_env_i(rdr), .tag_mod_i(tag),
    .rtcal_i(rtcal), .link_period_i(per), .tol_code_i(code), .quiet_i(quiet),
    .t1_ticks_o(t1), .t1_valid_o(v), .t1_early_o(e), .t1_late_o(l)
  );

  // window restated from R4 with plain integers
  function automatic int frac_of(input int c);
    if (c == 0) return 10;
    if (c == 1) return 26;
    if (c == 2) return 38;
    return 56;
  endfunction
  function automatic int win_lo();
    int n, s;
    n = (int'(rtcal) > 10 * int'(per)) ? int'(rtcal) : 10 * int'(per);
    s = (n * (256 - frac_of(int'(code)))) / 256 - 80;
    return (s < 0) ? 0 : s;
  endfunction
  function automatic int win_hi();
    int n, s;
    n = (int'(rtcal) > 10 * int'(per)) ? int'(rtcal) : 10 * int'(per);
    s = (n * (256 + frac_of(int'(code)))) / 256 + 80;
    return (s > 65534) ? 65534 : s;
  endfunction

  // behavioural reference, advanced on each rising edge
  int  cyc = 0, m_phase = 0, m_start = 0, m_t1 = 0, el;
  bit  m_prev_r = 1, m_prev_t = 1, m_v = 0, m_e = 0, m_l = 0, rr, tr;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_t1 = 0; m_v = 0; m_e = 0; m_l = 0;
      m_prev_r = 1; m_prev_t = 1;
    end else begin
      rr = rdr && !m_prev_r;
      tr = tag && !m_prev_t;
      el = cyc - m_start;
      m_v = 0; m_e = 0; m_l = 0;
      if (m_phase == 0) begin
        if (rr) begin m_phase = 1; m_start = cyc; end
      end else if (m_phase == 1) begin
        if (tr && rdr) begin m_e = 1; m_t1 = el; m_phase = 0; end
        else if (rr) m_start = cyc;
        else if (rdr && el > int'(quiet)) m_phase = 2;
      end else begin
        if (tr) begin
          if (el < win_lo()) m_e = 1;
          else if (el > win_hi()) m_l = 1;
          else m_v = 1;
          m_t1 = el; m_phase = 0;
        end else if (el > win_hi()) begin
          m_l = 1; m_t1 = el; m_phase = 0;
        end
      end
      m_prev_r = rdr;
      m_prev_t = tag;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (v !== m_v) begin errors++; $display("FAIL R5 cycle %0d valid=%0b exp %0b", cyc, v, m_v); end
      else if (e !== m_e) begin errors++; $display("FAIL R6 cycle %0d early=%0b exp %0b", cyc, e, m_e); end
      else if (l !== m_l) begin errors++; $display("FAIL R7 cycle %0d late=%0b exp %0b", cyc, l, m_l); end
      else if (int'(t1) != m_t1) begin errors++; $display("FAIL R3 cycle %0d t1=%0d exp %0d", cyc, t1, m_t1); end
    end
  end

  // kind: 1 valid, 2 early, 3 late
  task automatic check_result(input int kind, input int exp_t1, input string req);
    int act;
    act = v ? 1 : e ? 2 : l ? 3 : 0;
    checks++;
    if (act != kind || int'(t1) != exp_t1 || (int'(v) + int'(e) + int'(l)) > 1) begin
      errors++;
      $display("FAIL %s kind=%0d t1=%0d exp kind=%0d t1=%0d", req, act, t1, kind, exp_t1);
    end
  endtask

  task automatic cmd(input int nbits, input bit glitch);
    for (int b = 0; b < nbits; b++) begin
      rdr = 1'b0;
      if (glitch) begin
        tag = 1'b1; repeat (3) @(negedge clk);
        tag = 1'b0; repeat (17) @(negedge clk);
      end else repeat (20) @(negedge clk);
      rdr = 1'b1; repeat (40) @(negedge clk);
    end
    rdr = 1'b0; repeat (20) @(negedge clk);
    rdr = 1'b1;
  endtask

  task automatic measure(input int d, input int kind, input int exp_t1, input string req);
    cmd(2, 1'b0);
    repeat (d) @(negedge clk);
    tag = 1'b1;
    @(negedge clk);
    check_result(kind, exp_t1, req);
    tag = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic no_reply(input int exp_t1, input string req);
    int n;
    cmd(1, 1'b0);
    n = 0;
    while (!(v || e || l) && n < exp_t1 + 50) begin @(negedge clk); n++; end
    check_result(3, exp_t1, req);
    repeat (10) @(negedge clk);
  endtask

  task automatic set_cfg(input int rt, input int p, input int c);
    rtcal = CW'(rt); per = LW'(p); code = 2'(c);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (t1 !== '0 || v || e || l) begin errors++; $display("FAIL R1 in reset t1=%0d flags=%0b%0b%0b exp 0 000", t1, v, e, l); end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1 first cycle after reset
    if (t1 !== '0 || v || e || l) begin errors++; $display("FAIL R1 after reset t1=%0d flags=%0b%0b%0b exp 0 000", t1, v, e, l); end
    repeat (5) @(negedge clk);

    // window 404..835
    measure(500, 1, 500, "R2/R3 valid");
    measure(404, 1, 404, "R5 lower edge");
    measure(403, 2, 403, "R6 below window");
    measure(835, 1, 835, "R5 upper edge");
    measure(836, 3, 836, "R7 tag beyond window");
    measure(50, 2, 50, "R6 reply inside command");
    no_reply(836, "R7 no reply");

    // R9: tag edges during command gaps are ignored
    cmd(3, 1'b1);
    repeat (600) @(negedge clk);
    tag = 1'b1; @(negedge clk);
    check_result(1, 600, "R9 gap edges ignored");
    tag = 1'b0; repeat (10) @(negedge clk);

    // R9: idle tag edges produce nothing and leave t1 alone
    begin
      bit seen = 0;
      tag = 1'b1; repeat (5) @(negedge clk); tag = 1'b0;
      repeat (30) begin @(negedge clk); if (v || e || l) seen = 1; end
      checks++;
      if (seen || t1 !== 16'd600) begin errors++; $display("FAIL R9 idle strobe=%0b t1=%0d exp 0 600", seen, t1); end
    end

    // R10: new configuration, calibration dominant, window 279..520
    set_cfg(400, 20, 1);
    measure(300, 1, 300, "R4/R10 valid");
    measure(278, 2, 278, "R4/R10 early");

    // long link, window 9529..10470
    set_cfg(1000, 1000, 0);
    measure(9529, 1, 9529, "R4 long lower edge");
    no_reply(10471, "R7 long no reply");

    // lower bound clamped to zero, window 0..140
    set_cfg(50, 4, 3);
    measure(120, 1, 120, "R4 clamped window");

    // R8: single-cycle strobe seen once more at the port
    cmd(1, 1'b0);
    repeat (130) @(negedge clk);
    tag = 1'b1; @(negedge clk); @(negedge clk);
    checks++;
    if (v || e || l || t1 !== 16'd130) begin errors++; $display("FAIL R8 strobe held flags=%0b%0b%0b t1=%0d exp 000 130", v, e, l, t1); end
    tag = 1'b0; repeat (5) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL R8 watchdog expired at cycle %0d exp completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule